// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block is the host side of an asynchronous NAND flash bus. A client hands it one operation at a time (page read, page program or block erase) with a row (page) address, a column address, a beat count and a width choice. The sequencer then walks the flash through its command, address, data and busy phases. It generates chip enable, the write and read strobes and the two latch qualifiers, and it drives or samples a 16-bit data bus. It then waits on the open-drain ready line.

Every strobe cycle is built from a clock-cycle counter: the strobe is low for `T_LO` clocks and high for `T_HI` clocks, and the latch qualifiers and bus data stay steady for the whole cycle, so they hold before and after the rising edge. Commands and address bytes use only the low byte of the bus. The upper byte carries data only when 16-bit mode is chosen. After the confirm command the sequencer ignores the ready line for `T_WB` clocks. It then polls the synchronised line until the line is high or until the busy count reaches the client's `busy_limit`. Program and erase close with a status command and one status read.

The state machine has the states IDLE, CMD1 (first opcode), ADDR (address bytes), WDATA (write beats), CMD2 (confirm opcode), BUSY (ready wait), RDATA (read beats), SCMD (status opcode), STAT (status read) and DONE (one-cycle completion). The transitions are: IDLE→CMD1 on an accepted request; CMD1→ADDR; ADDR→WDATA for a program with beats, else ADDR→CMD2; WDATA→CMD2 after the last beat; CMD2→BUSY; BUSY→RDATA (read with beats), BUSY→DONE (read without beats, or timeout), BUSY→SCMD (program/erase); SCMD→STAT; STAT→DONE; RDATA→DONE after the last beat; DONE→IDLE.

Top module: `nand_seq`

## Requirements
- R1: After reset nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale and nand_dq_oe are low, and op_ready is high.
- R2: Every write or read strobe pulse is low for exactly T_LO clocks, and between two pulses of one operation the strobes stay high for at least T_HI clocks.
- R3: A command cycle has nand_cle high and nand_ale low, with the opcode on bits 7:0 and zero on bits 15:8. Read sends 00h then 30h; program sends 80h then 10h then status 70h; erase sends 60h then D0h then 70h.
- R4: An address cycle has nand_ale high and nand_cle low, with zero on bits 15:8. Read and program send five bytes: column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16, each zero-extended. Erase sends only the three row bytes.
- R5: A program sends op_len write cycles with both latch qualifiers low, taking wr_data in order, and pulses wr_take once at the end of each cycle. When op_wide is 0, bits 15:8 are driven as zero.
- R6: A read returns op_len words on rd_valid pulses in column order, each the bus value sampled in the last low clock of its read pulse. When op_wide is 0, rd_data bits 15:8 are zero.
- R7: nand_dq_oe is high only in command, address and write-data cycles, and never while nand_re_n is low.
- R8: After the confirm command no further strobe falls until the synchronised ready line has been seen high. If the busy count reaches busy_limit first, the operation ends with err_timeout set and without data or status cycles.
- R9: After program or erase, err_status equals bit 0 of the status byte read after the 70h command. A read operation leaves it 0.
- R10: A request is taken when op_valid and op_ready are both high, with op_kind 0 = read, 1 = program, 2 = erase. op_kind 3 is ignored. op_done is a single-cycle pulse per operation, followed by op_ready.
- R11: nand_ce_n is low from the cycle after acceptance until op_done, and it is low whenever a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| op_row | input | ROW_W | Page (row) address; block address for erase |
| op_col | input | COL_W | Starting column |
| op_len | input | LEN_W | Number of data beats |
| op_wide | input | 1 | 1 selects the 16-bit data phase |
| busy_limit | input | TO_W | Busy-wait timeout in clocks |
| op_ready | output | 1 | Idle, request can be taken |
| wr_data | input | 16 | Current write word |
| wr_take | output | 1 | Current write word consumed |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | rd_data valid |
| op_done | output | 1 | Operation finished (one cycle) |
| err_timeout | output | 1 | Busy wait expired |
| err_status | output | 1 | Status bit 0 from the flash |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch qualifier |
| nand_ale | output | 1 | Address latch qualifier |
| nand_dq_o | output | 16 | Bus output value |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 16 | Bus input value |
| nand_rb_n | input | 1 | Ready (high) / busy (low), asynchronous |

## Verification
A behavioural flash model in the bench logs every cycle latched on a write-strobe rising edge and answers read pulses with an arithmetic pattern of row and column. The sweep runs each operation kind in both bus widths with beat counts of zero, one and several, and with addresses at the ends of the column and row ranges. These runs separate address byte ordering, wide versus narrow masking and skipped data phases. Program and erase run with the status bit both set and clear, which shows that the flag comes from the bus and not from a constant. Busy lengths are varied and a stuck-busy device is used for each kind, which tells an honest ready wait apart from a timeout. A reserved request code shows that nothing starts.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_WDATA,
        S_CMD2,
        S_BUSY,
        S_RDATA,
        S_SCMD,
        S_STAT,
        S_DONE
    } state_e;

    localparam logic [7:0] OPC_READ_A   = 8'h00;
    localparam logic [7:0] OPC_READ_B   = 8'h30;
    localparam logic [7:0] OPC_PROG_A   = 8'h80;
    localparam logic [7:0] OPC_PROG_B   = 8'h10;
    localparam logic [7:0] OPC_ERASE_A  = 8'h60;
    localparam logic [7:0] OPC_ERASE_B  = 8'hD0;
    localparam logic [7:0] OPC_STATUS   = 8'h70;

    localparam logic [2:0] ADDR_LAST    = 3'd4;
    localparam logic [2:0] ADDR_ROW0    = 3'd2;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic rb_ready
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], rb_n_async};
        end
    end

    assign rb_ready = sh_q[STAGES-1];

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
    parameter int T_LO = 2,
    parameter int T_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic lo,
    output logic last,
    output logic sample
);
    localparam int TOT = T_LO + T_HI;
    localparam int CW  = $clog2(TOT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lo_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!go || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign lo     = go && (cnt_q < CW'(T_LO));
    assign last   = go && (cnt_q == CW'(TOT - 1));
    assign sample = go && (cnt_q == CW'(T_LO - 1));

    // run length of the low phase, kept for the width check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
        end else if (lo) begin
            lo_run_q <= lo_run_q + 1'b1;
        end else begin
            lo_run_q <= '0;
        end
    end

    // R2: a low phase ends after exactly T_LO clocks
    p_lo_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo) |-> (lo_run_q == CW'(T_LO)));

    // R2: the beat closes in its high phase
    p_last_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !lo);

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_W       = 12,
    parameter int ROW_W       = 17,
    parameter int LEN_W       = 12,
    parameter int TO_W        = 20,
    parameter int T_LO        = 2,
    parameter int T_HI        = 2,
    parameter int T_WB        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [ROW_W-1:0] op_row,
    input  logic [COL_W-1:0] op_col,
    input  logic [LEN_W-1:0] op_len,
    input  logic             op_wide,
    input  logic [TO_W-1:0]  busy_limit,
    output logic             op_ready,
    input  logic [15:0]      wr_data,
    output logic             wr_take,
    output logic [15:0]      rd_data,
    output logic             rd_valid,
    output logic             op_done,
    output logic             err_timeout,
    output logic             err_status,
    output logic             nand_ce_n,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic [15:0]      nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [15:0]      nand_dq_i,
    input  logic             nand_rb_n
);
    localparam logic [1:0] KIND_RSVD = 2'd3;

    state_e             state_q, state_d;
    op_e                kind_q;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic [LEN_W-1:0]   len_q;
    logic               wide_q;
    logic [2:0]         aidx_q;
    logic [LEN_W-1:0]   bcnt_q;
    logic [TO_W-1:0]    wcnt_q;
    logic               err_to_q, err_st_q;
    logic [15:0]        rd_q;
    logic               rd_v_q;

    logic               rb_ready;
    logic               beat_go, beat_is_re, beat_lo, beat_last, beat_sample;
    logic               accept, rb_go, to_hit, last_beat;
    logic [15:0]        col_ext;
    logic [23:0]        row_ext;
    logic [7:0]         cmd_byte, addr_byte;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_n_async (nand_rb_n),
        .rb_ready   (rb_ready)
    );

    nand_strobe_gen #(.T_LO(T_LO), .T_HI(T_HI)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (beat_go),
        .lo     (beat_lo),
        .last   (beat_last),
        .sample (beat_sample)
    );

    assign beat_is_re = (state_q == S_RDATA) || (state_q == S_STAT);
    assign beat_go    = (state_q == S_CMD1) || (state_q == S_ADDR) ||
                        (state_q == S_WDATA) || (state_q == S_CMD2) ||
                        (state_q == S_SCMD) || beat_is_re;

    assign accept    = (state_q == S_IDLE) && op_valid && (op_kind != KIND_RSVD);
    assign rb_go     = (wcnt_q >= TO_W'(T_WB)) && rb_ready;
    assign to_hit    = !rb_go && (wcnt_q == busy_limit);
    assign last_beat = (bcnt_q == len_q - LEN_W'(1));
    assign col_ext   = 16'(col_q);
    assign row_ext   = 24'(row_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_CMD1;
            S_CMD1:  if (beat_last) state_d = S_ADDR;
            S_ADDR:  if (beat_last && aidx_q == ADDR_LAST) begin
                         if (kind_q == OP_PROG && len_q != '0) state_d = S_WDATA;
                         else                                  state_d = S_CMD2;
                     end
            S_WDATA: if (beat_last && last_beat) state_d = S_CMD2;
            S_CMD2:  if (beat_last) state_d = S_BUSY;
            S_BUSY:  if (rb_go) begin
                         if (kind_q != OP_READ)  state_d = S_SCMD;
                         else if (len_q == '0)   state_d = S_DONE;
                         else                    state_d = S_RDATA;
                     end else if (to_hit) begin
                         state_d = S_DONE;
                     end
            S_RDATA: if (beat_last && last_beat) state_d = S_DONE;
            S_SCMD:  if (beat_last) state_d = S_STAT;
            S_STAT:  if (beat_last) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kind_q   <= OP_READ;
            row_q    <= '0;
            col_q    <= '0;
            len_q    <= '0;
            wide_q   <= 1'b0;
            aidx_q   <= '0;
            bcnt_q   <= '0;
            wcnt_q   <= '0;
            err_to_q <= 1'b0;
            err_st_q <= 1'b0;
            rd_q     <= '0;
            rd_v_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_v_q  <= 1'b0;
            if (accept) begin
                kind_q   <= op_e'(op_kind);
                row_q    <= op_row;
                col_q    <= op_col;
                len_q    <= op_len;
                wide_q   <= op_wide;
                aidx_q   <= (op_e'(op_kind) == OP_ERASE) ? ADDR_ROW0 : 3'd0;
                bcnt_q   <= '0;
                err_to_q <= 1'b0;
                err_st_q <= 1'b0;
            end
            if (state_q == S_ADDR && beat_last) aidx_q <= aidx_q + 3'd1;
            if ((state_q == S_WDATA || state_q == S_RDATA) && beat_last) bcnt_q <= bcnt_q + LEN_W'(1);
            if (state_q == S_BUSY) wcnt_q <= wcnt_q + TO_W'(1);
            else                   wcnt_q <= '0;
            if (state_q == S_BUSY && to_hit) err_to_q <= 1'b1;
            if (state_q == S_STAT && beat_sample) err_st_q <= nand_dq_i[0];
            if (state_q == S_RDATA && beat_sample) begin
                rd_v_q <= 1'b1;
                rd_q   <= wide_q ? nand_dq_i : {8'h00, nand_dq_i[7:0]};
            end
        end
    end

    // byte selection for command and address cycles
    always_comb begin
        unique case (state_q)
            S_CMD1:  cmd_byte = (kind_q == OP_READ) ? OPC_READ_A :
                                (kind_q == OP_PROG) ? OPC_PROG_A : OPC_ERASE_A;
            S_CMD2:  cmd_byte = (kind_q == OP_READ) ? OPC_READ_B :
                                (kind_q == OP_PROG) ? OPC_PROG_B : OPC_ERASE_B;
            S_SCMD:  cmd_byte = OPC_STATUS;
            default: cmd_byte = 8'h00;
        endcase
        unique case (aidx_q)
            3'd0:    addr_byte = col_ext[7:0];
            3'd1:    addr_byte = col_ext[15:8];
            3'd2:    addr_byte = row_ext[7:0];
            3'd3:    addr_byte = row_ext[15:8];
            default: addr_byte = row_ext[23:16];
        endcase
    end

    // outputs
    always_comb begin
        op_ready    = (state_q == S_IDLE);
        op_done     = (state_q == S_DONE);
        nand_ce_n   = (state_q == S_IDLE) || (state_q == S_DONE);
        nand_cle    = (state_q == S_CMD1) || (state_q == S_CMD2) || (state_q == S_SCMD);
        nand_ale    = (state_q == S_ADDR);
        nand_we_n   = !(beat_lo && !beat_is_re);
        nand_re_n   = !(beat_lo && beat_is_re);
        nand_dq_oe  = beat_go && !beat_is_re;
        wr_take     = (state_q == S_WDATA) && beat_last;
        if (nand_cle)                nand_dq_o = {8'h00, cmd_byte};
        else if (nand_ale)           nand_dq_o = {8'h00, addr_byte};
        else if (state_q == S_WDATA) nand_dq_o = wide_q ? wr_data : {8'h00, wr_data[7:0]};
        else                         nand_dq_o = 16'h0000;
        rd_data     = rd_q;
        rd_valid    = rd_v_q;
        err_timeout = err_to_q;
        err_status  = err_st_q;
    end

    // R7: bus never driven while the flash may drive it
    p_oe_off_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    // R3: latch qualifiers never both high
    p_cle_ale_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R2: one strobe at a time
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R11: a strobe only toggles with chip enable active
    p_ce_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R10: completion is one cycle, then idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (op_ready && !op_done));

    // R8: a timeout is reported together with completion
    p_timeout_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> op_done);

    // R5: a write word is released only after its strobe rose
    p_take_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (nand_we_n && nand_dq_oe));

endmodule

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
    localparam int TLO = 3;
    localparam int THI = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [16:0] op_row;
    logic [11:0] op_col;
    logic [11:0] op_len;
    logic        op_wide;
    logic [19:0] busy_limit;
    logic        op_ready, wr_take, rd_valid, op_done, err_timeout, err_status;
    logic [15:0] wr_data, rd_data, nand_dq_o;
    logic [15:0] nand_dq_i;
    logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe;
    logic        nand_rb_n;

    always #4 clk = ~clk;

    nand_seq #(.T_LO(TLO), .T_HI(THI)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_row(op_row), .op_col(op_col), .op_len(op_len), .op_wide(op_wide),
        .busy_limit(busy_limit), .op_ready(op_ready), .wr_data(wr_data),
        .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .op_done(op_done), .err_timeout(err_timeout), .err_status(err_status),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [23:0] r, input logic [15:0] c);
        logic [23:0] s;
        s = r * 24'd5 + {8'h00, c} * 24'd3 + 24'd7;
        return s[15:0] ^ {c[7:0], r[7:0]};
    endfunction

    function automatic logic [15:0] wpat(input int k);
        return 16'(k) * 16'd37 + 16'hA55A;
    endfunction

    // ---------------- flash model ----------------
    logic [1:0]  lg_k [0:2047];
    logic [15:0] lg_v [0:2047];
    logic [15:0] rd_log [0:1023];
    logic [7:0]  ab [0:7];
    int lg_n = 0, rd_n = 0, wk = 0, done_cnt = 0;
    int str_err = 0, oe_err = 0, cyc = 0, ce_cyc = 0;
    int lo_cnt = 0, hi_cnt = 0, ab_n = 0, busy_left = 0, conf_cyc = 0, gap_last = 0;
    int busy_len = 10;
    bit had_pulse = 0, gap_pending = 0, stat_mode = 0, stuck = 0, fail_bit = 0, confirm;
    bit prev_we = 1, prev_re = 1, cap_to = 0, cap_st = 0;
    logic [23:0] row_m = '0;
    logic [15:0] col_m = '0;

    assign wr_data = wpat(wk);

    initial begin
        nand_dq_i = 16'h0000;
        nand_rb_n = 1'b1;
    end

    always @(negedge clk) begin
        cyc++;
        confirm = 0;
        if (!nand_ce_n) ce_cyc++;
        if (!nand_re_n && nand_dq_oe) oe_err++;
        if (!prev_we && nand_we_n) begin
            if (lo_cnt != TLO) str_err++;
            if (lg_n < 2048) begin
                lg_k[lg_n] = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
                lg_v[lg_n] = nand_dq_o;
                lg_n++;
            end
            if (nand_cle) begin
                case (nand_dq_o[7:0])
                    8'h00: begin ab_n = 0; stat_mode = 0; end
                    8'h80, 8'h60: ab_n = 0;
                    8'h70: stat_mode = 1;
                    8'h30: begin
                        col_m = {ab[1], ab[0]};
                        row_m = {ab[4], ab[3], ab[2]};
                        confirm = 1;
                    end
                    8'h10, 8'hD0: confirm = 1;
                    default: ;
                endcase
            end else if (nand_ale && ab_n < 8) begin
                ab[ab_n] = nand_dq_o[7:0];
                ab_n++;
            end
            if (confirm) begin
                busy_left = busy_len;
                conf_cyc = cyc;
                gap_pending = 1;
            end
        end
        if (!prev_re && nand_re_n) begin
            if (lo_cnt != TLO) str_err++;
            if (!stat_mode) col_m = col_m + 16'd1;
        end
        if ((prev_we && !nand_we_n) || (prev_re && !nand_re_n)) begin
            if (had_pulse && hi_cnt < THI) str_err++;
            if (gap_pending) begin gap_last = cyc - conf_cyc; gap_pending = 0; end
            if (prev_re && !nand_re_n)
                nand_dq_i = stat_mode ? {8'h00, 7'h70, fail_bit} : pat(row_m, col_m);
        end
        if (!nand_we_n || !nand_re_n) begin lo_cnt++; hi_cnt = 0; had_pulse = 1; end
        else begin lo_cnt = 0; hi_cnt++; end
        if (nand_ce_n) had_pulse = 0;
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        if (!confirm && busy_left > 0) busy_left--;
        nand_rb_n = !(stuck || busy_left != 0);
        if (rd_valid && rd_n < 1024) begin rd_log[rd_n] = rd_data; rd_n++; end
        if (wr_take) wk++;
        if (op_done) begin done_cnt++; cap_to = err_timeout; cap_st = err_status; end
    end

    // ---------------- operation runner ----------------
    logic [1:0]  ex_k [0:63];
    logic [15:0] ex_v [0:63];
    int ex_n;

    task automatic push(input logic [1:0] k, input logic [15:0] v);
        ex_k[ex_n] = k;
        ex_v[ex_n] = v;
        ex_n++;
    endtask

    task automatic run_op(input logic [1:0] kind, input logic [16:0] row, input logic [11:0] col,
                          input logic [11:0] len, input logic wide, input bit fail,
                          input int blen, input bit stk, input logic [19:0] limit);
        int b_lg, b_rd, b_wk, b_dn, b_str, b_oe, g;
        logic [15:0] msk, e;
        logic [23:0] r24;
        string t;
        b_lg = lg_n; b_rd = rd_n; b_wk = wk; b_dn = done_cnt; b_str = str_err; b_oe = oe_err;
        msk = wide ? 16'hFFFF : 16'h00FF;
        r24 = {7'h00, row};
        fail_bit = fail; busy_len = blen; stuck = stk;
        ex_n = 0;
        push(2'd0, (kind == 2'd0) ? 16'h0000 : (kind == 2'd1) ? 16'h0080 : 16'h0060);
        if (kind != 2'd2) begin
            push(2'd1, {8'h00, col[7:0]});
            push(2'd1, {12'h000, col[11:8]});
        end
        push(2'd1, {8'h00, r24[7:0]});
        push(2'd1, {8'h00, r24[15:8]});
        push(2'd1, {8'h00, r24[23:16]});
        if (kind == 2'd1) for (int j = 0; j < int'(len); j++) push(2'd2, wpat(b_wk + j) & msk);
        push(2'd0, (kind == 2'd0) ? 16'h0030 : (kind == 2'd1) ? 16'h0010 : 16'h00D0);
        if (kind != 2'd0 && !stk) push(2'd0, 16'h0070);

        @(negedge clk);
        op_kind = kind; op_row = row; op_col = col; op_len = len; op_wide = wide;
        busy_limit = limit; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        g = 0;
        #1;
        while (done_cnt == b_dn && g < 5000) begin @(negedge clk); #1; g++; end
        stuck = 0;
        repeat (4) @(negedge clk);
        #1;
        // R10 / R11: exactly one completion pulse, idle afterwards
        chk(done_cnt - b_dn == 1, "R10 done pulses", done_cnt - b_dn, 1);
        chk(op_ready && nand_ce_n, "R11 idle after done", {op_ready, nand_ce_n}, 2'b11);
        // R8 / R9: flags at completion
        chk(cap_to == stk, "R8 timeout flag", cap_to, stk);
        chk(cap_st == ((kind != 2'd0 && !stk) ? fail : 1'b0), "R9 status flag", cap_st,
            (kind != 2'd0 && !stk) ? fail : 1'b0);
        // R3 / R4 / R5: latched cycle sequence
        chk(lg_n - b_lg == ex_n, "R3 cycle count", lg_n - b_lg, ex_n);
        for (int i = 0; i < ex_n && i < lg_n - b_lg; i++) begin
            t = (ex_k[i] == 2'd0) ? "R3 command" : (ex_k[i] == 2'd1) ? "R4 address" : "R5 write data";
            chk(lg_k[b_lg + i] == ex_k[i] && lg_v[b_lg + i] == ex_v[i], t,
                {lg_k[b_lg + i], lg_v[b_lg + i]}, {ex_k[i], ex_v[i]});
        end
        chk(wk - b_wk == ((kind == 2'd1) ? int'(len) : 0), "R5 take count", wk - b_wk,
            (kind == 2'd1) ? int'(len) : 0);
        // R6: read data
        chk(rd_n - b_rd == ((kind == 2'd0 && !stk) ? int'(len) : 0), "R6 read count", rd_n - b_rd,
            (kind == 2'd0 && !stk) ? int'(len) : 0);
        for (int j = 0; j < rd_n - b_rd; j++) begin
            e = pat(r24, {4'h0, col} + 16'(j)) & msk;
            chk(rd_log[b_rd + j] == e, "R6 read word", rd_log[b_rd + j], e);
        end
        // R2 / R7: strobe shape and bus ownership
        chk(str_err == b_str, "R2 strobe widths", str_err - b_str, 0);
        chk(oe_err == b_oe, "R7 drive during read", oe_err - b_oe, 0);
        // R8: nothing strobed before the device released busy
        if (!stk && !(kind == 2'd0 && len == 0))
            chk(gap_last >= blen, "R8 busy honoured", gap_last, blen);
    endtask

    // ---------------- stimulus ----------------
    int wd = 0;
    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'd0; op_row = '0; op_col = '0;
        op_len = '0; op_wide = 1'b0; busy_limit = 20'd5000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes high",
            {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 qualifiers low",
            {nand_cle, nand_ale, nand_dq_oe}, 3'b000);
        chk(op_ready, "R1 ready", op_ready, 1);

        // R10: reserved kind is ignored
        begin
            int c0, l0;
            c0 = ce_cyc; l0 = lg_n;
            @(negedge clk);
            op_kind = 2'd3; op_valid = 1'b1;
            repeat (6) @(negedge clk);
            op_valid = 1'b0;
            #1;
            chk(op_ready && ce_cyc == c0 && lg_n == l0, "R10 reserved kind ignored",
                ce_cyc - c0, 0);
        end

        for (int w = 0; w < 2; w++) begin
            run_op(2'd0, 17'h00000, 12'h000, 12'd1, w[0], 0, 12, 0, 20'd5000);
            run_op(2'd0, 17'h1ABCD, 12'hFFE, 12'd3, w[0], 0, 25, 0, 20'd5000);
            run_op(2'd0, 17'h00400, 12'h800, 12'd0, w[0], 0, 8, 0, 20'd5000);
            run_op(2'd1, 17'h0F0F0, 12'h123, 12'd4, w[0], 0, 30, 0, 20'd5000);
            run_op(2'd1, 17'h10001, 12'h000, 12'd1, w[0], 1, 15, 0, 20'd5000);
            run_op(2'd1, 17'h00002, 12'h7FF, 12'd0, w[0], 0, 10, 0, 20'd5000);
            run_op(2'd2, 17'h1FFC0, 12'h000, 12'd0, w[0], 0, 40, 0, 20'd5000);
            run_op(2'd2, 17'h00040, 12'h000, 12'd0, w[0], 1, 20, 0, 20'd5000);
        end
        // R8: stuck-busy device for each kind
        run_op(2'd0, 17'h00123, 12'h010, 12'd2, 1'b1, 0, 10, 1, 20'd60);
        run_op(2'd1, 17'h00321, 12'h020, 12'd2, 1'b0, 1, 10, 1, 20'd60);
        run_op(2'd2, 17'h00080, 12'h000, 12'd0, 1'b1, 1, 10, 1, 20'd60);
        // recovery after timeout
        run_op(2'd0, 17'h0AAAA, 12'h555, 12'd2, 1'b1, 0, 18, 0, 20'd5000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        for (wd = 0; wd < 150000; wd++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule